// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block sits between a host memory request port and the command pins of a DDR SDRAM. A three-bit mode field, written by software, sets what a host access does. In each of the special modes, every host access becomes one fixed DRAM command: a no-operation, a precharge of all banks, a load of the mode register or the extended mode register, or an auto refresh. Firmware can therefore step the memory through its power-up sequence one access at a time. In normal mode, an access produces only a strobe toward the regular access path, which lies outside this block.

The block also owns the clock-enable lines. The mode field returns to zero on every reset. The clock enables then stay low until software writes a non-zero mode value. From that point they stay high until the next reset.

For a mode register load, the host address bits from bit 3 upward are steered onto the low DRAM address lines, so the register value travels in the address of the access. A fast chip-select enable input is permitted only in normal mode. In any other mode, the block raises an error and keeps the enable from taking effect.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, the clock enables are low, the command pins show deselect {CS#,RAS#,CAS#,WE#}=1111, address and bank are zero, and the acknowledge and normal strobe are low. The mode field reads as 000, so a request made after reset is acknowledged with no command.
- R2: While the mode is 000, the clock enables stay low, and writing 000 again leaves them low. A request is acknowledged in the next cycle and issues no command.
- R3: The first write of a non-zero mode value drives all clock enables high in the cycle after the write. They stay high through later writes, including writes of 000, until reset.
- R4: In mode 001, an accepted request drives NOP (0111) with address 0 and bank 0 in the cycle after acceptance.
- R5: In mode 010, an accepted request drives precharge (0010) with address bit 10 high and all other address bits low.
- R6: In mode 011, an accepted request drives mode register load (0000) with bank 00. Address bits 10:0 equal host address bits 13:3, and address bits 12:11 are zero.
- R7: In mode 100, an accepted request drives the same 0000 command and address mapping as R6, with bank 01.
- R8: In mode 110, an accepted request drives auto refresh (0001) with address 0.
- R9: In the reserved mode 101, a request issues no command and is acknowledged in the next cycle.
- R10: In mode 111, a request raises the normal strobe for one cycle with the command pins at deselect. The acknowledge follows in the next cycle.
- R11: Each command lasts exactly one cycle, and the acknowledge rises for one cycle in the cycle after it. A request held high is accepted again only after the acknowledge, so at most one command is issued every three cycles.
- R12: When the fast chip-select enable is high and the mode is not 111, the error output is high and the effective enable output is low. In mode 111, the error is low and the enable passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 3 | New mode value |
| fast_cs_en | input | 1 | Requested fast chip-select enable |
| host_req | input | 1 | Host memory access request |
| host_addr | input | HA_W (32) | Host access address |
| host_ack | output | 1 | One-cycle acknowledge of the request |
| cmd_cs_n | output | 1 | DRAM chip select, active low |
| cmd_ras_n | output | 1 | DRAM row strobe, active low |
| cmd_cas_n | output | 1 | DRAM column strobe, active low |
| cmd_we_n | output | 1 | DRAM write enable, active low |
| dram_addr | output | ADDR_W (13) | DRAM address lines |
| dram_ba | output | BA_W (2) | DRAM bank address |
| cke | output | NUM_CKE (2) | Clock enables, one per rank |
| norm_strobe | output | 1 | One-cycle pulse toward the normal access path |
| fcs_err | output | 1 | Fast chip-select enabled outside normal mode |
| fast_cs_act | output | 1 | Effective fast chip-select enable |

## Verification
Directed passes walk every mode value in turn and compare the command nibble, address and bank against bench functions. This separates the four commands that share a pattern but differ in bank or address (mode and extended mode load, precharge with bit 10). Random passes draw the mode and a 32-bit host address from a seeded generator. Random upper address bits show that only bits 13:3 reach the DRAM address, and random mode order shows that the clock enables latch on the first non-zero write. A request held high for several cycles tells correct single-shot acceptance apart from re-triggering. A reset in the middle of a run shows that both the clock enables and the mode field return to their power-up values.

// File: rtl/dis_pkg.sv
package dis_pkg;

   typedef enum logic [2:0] {
      MODE_RESET = 3'b000,
      MODE_NOP   = 3'b001,
      MODE_PALL  = 3'b010,
      MODE_MRS   = 3'b011,
      MODE_EMRS  = 3'b100,
      MODE_RSVD  = 3'b101,
      MODE_REF   = 3'b110,
      MODE_NORM  = 3'b111
   } dis_mode_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } dis_cmd_t;

   localparam dis_cmd_t CMD_DESEL = 4'b1111;
   localparam dis_cmd_t CMD_NOP   = 4'b0111;
   localparam dis_cmd_t CMD_PRE   = 4'b0010;
   localparam dis_cmd_t CMD_LMR   = 4'b0000;
   localparam dis_cmd_t CMD_REF   = 4'b0001;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_ACK   = 2'd2
   } dis_state_e;

endpackage

// File: rtl/dis_mode_ctl.sv
module dis_mode_ctl
   import dis_pkg::*;
#(
   parameter int NUM_CKE = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_wr,
   input  logic [2:0]         mode_wdata,
   output dis_mode_e          mode_q,
   output logic [NUM_CKE-1:0] cke
);

   logic set_cke;

   assign set_cke = mode_wr && (mode_wdata != 3'b000);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
      end else if (mode_wr) begin
         mode_q <= dis_mode_e'(mode_wdata);
      end
   end

   // one sticky flop per rank so each enable can be placed near its pins
   for (genvar i = 0; i < NUM_CKE; i++) begin : g_cke
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q <= 1'b0;
         end else if (set_cke) begin
            en_q <= 1'b1;
         end
      end
      assign cke[i] = en_q;
   end

endmodule

// File: rtl/dis_cmd_map.sv
module dis_cmd_map
   import dis_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int MRS_BITS = 11,
   parameter int AP_BIT   = 10
) (
   input  dis_mode_e           mode,
   input  logic [MRS_BITS-1:0] reg_val,
   output logic                issue,
   output logic                to_norm,
   output dis_cmd_t            cmd,
   output logic [ADDR_W-1:0]   addr,
   output logic [BA_W-1:0]     ba
);

   localparam logic [BA_W-1:0] BA_MRS  = '0;
   localparam logic [BA_W-1:0] BA_EMRS = BA_W'(1);

   always_comb begin
      issue   = 1'b0;
      to_norm = 1'b0;
      cmd     = CMD_DESEL;
      addr    = '0;
      ba      = '0;
      case (mode)
         MODE_NOP: begin
            issue = 1'b1;
            cmd   = CMD_NOP;
         end
         MODE_PALL: begin
            issue        = 1'b1;
            cmd          = CMD_PRE;
            addr[AP_BIT] = 1'b1;
         end
         MODE_MRS: begin
            issue                = 1'b1;
            cmd                  = CMD_LMR;
            addr[MRS_BITS-1:0]   = reg_val;
            ba                   = BA_MRS;
         end
         MODE_EMRS: begin
            issue                = 1'b1;
            cmd                  = CMD_LMR;
            addr[MRS_BITS-1:0]   = reg_val;
            ba                   = BA_EMRS;
         end
         MODE_REF: begin
            issue = 1'b1;
            cmd   = CMD_REF;
         end
         MODE_NORM: begin
            to_norm = 1'b1;
         end
         default: begin
            issue   = 1'b0;
            to_norm = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dis_seq_ctl.sv
module dis_seq_ctl
   import dis_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              issue,
   input  logic              to_norm,
   input  dis_cmd_t          cmd_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BA_W-1:0]   ba_in,
   output logic              host_ack,
   output dis_cmd_t          cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BA_W-1:0]   ba_q,
   output logic              norm_q
);

   dis_state_e state_q;
   dis_state_e state_d;
   logic       accept;

   assign accept = (state_q == ST_IDLE) && host_req;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (host_req) state_d = (issue || to_norm) ? ST_ISSUE : ST_ACK;
         ST_ISSUE: state_d = ST_ACK;
         ST_ACK:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= CMD_DESEL;
         addr_q  <= '0;
         ba_q    <= '0;
         norm_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept && issue) begin
            cmd_q  <= cmd_in;
            addr_q <= addr_in;
            ba_q   <= ba_in;
         end else begin
            cmd_q  <= CMD_DESEL;
            addr_q <= '0;
            ba_q   <= '0;
         end
         norm_q <= accept && to_norm;
      end
   end

   assign host_ack = (state_q == ST_ACK);

endmodule

// File: rtl/dis_fcs_guard.sv
module dis_fcs_guard
   import dis_pkg::*;
#(
   parameter bit FCS_GATE = 1'b1
) (
   input  dis_mode_e mode,
   input  logic      fast_cs_en,
   output logic      fcs_err,
   output logic      fast_cs_act
);

   logic in_norm;

   assign in_norm = (mode == MODE_NORM);
   assign fcs_err = fast_cs_en && !in_norm;

   if (FCS_GATE) begin : g_gate
      assign fast_cs_act = fast_cs_en && in_norm;
   end else begin : g_flag_only
      assign fast_cs_act = fast_cs_en;
   end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
   import dis_pkg::*;
#(
   parameter int HA_W     = 32,
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int NUM_CKE  = 2,
   parameter int MAP_LSB  = 3,
   parameter int MRS_BITS = 11,
   parameter int AP_BIT   = 10,
   parameter bit FCS_GATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_wr,
   input  logic [2:0]         mode_wdata,
   input  logic               fast_cs_en,
   input  logic               host_req,
   input  logic [HA_W-1:0]    host_addr,
   output logic               host_ack,
   output logic               cmd_cs_n,
   output logic               cmd_ras_n,
   output logic               cmd_cas_n,
   output logic               cmd_we_n,
   output logic [ADDR_W-1:0]  dram_addr,
   output logic [BA_W-1:0]    dram_ba,
   output logic [NUM_CKE-1:0] cke,
   output logic               norm_strobe,
   output logic               fcs_err,
   output logic               fast_cs_act
);

   localparam int MAP_MSB = MAP_LSB + MRS_BITS - 1;

   if (MAP_MSB >= HA_W) begin : g_bad_map
      $error("register value field runs past the host address");
   end
   if (MRS_BITS > ADDR_W) begin : g_bad_mrs
      $error("register value wider than the DRAM address");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("all-bank bit outside the DRAM address");
   end
   if (BA_W < 1 || NUM_CKE < 1) begin : g_bad_width
      $error("bank width and rank count must be at least one");
   end

   dis_mode_e           mode_q;
   logic                dec_issue;
   logic                dec_norm;
   dis_cmd_t            dec_cmd;
   logic [ADDR_W-1:0]   dec_addr;
   logic [BA_W-1:0]     dec_ba;
   dis_cmd_t            cmd_q;
   logic [MRS_BITS-1:0] reg_val;
   logic                unused_ha;

   assign reg_val   = host_addr[MAP_MSB:MAP_LSB];
   assign unused_ha = ^host_addr;

   dis_mode_ctl #(
      .NUM_CKE (NUM_CKE)
   ) i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_wr    (mode_wr),
      .mode_wdata (mode_wdata),
      .mode_q     (mode_q),
      .cke        (cke)
   );

   dis_cmd_map #(
      .ADDR_W   (ADDR_W),
      .BA_W     (BA_W),
      .MRS_BITS (MRS_BITS),
      .AP_BIT   (AP_BIT)
   ) i_map (
      .mode    (mode_q),
      .reg_val (reg_val),
      .issue   (dec_issue),
      .to_norm (dec_norm),
      .cmd     (dec_cmd),
      .addr    (dec_addr),
      .ba      (dec_ba)
   );

   dis_seq_ctl #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W)
   ) i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_req),
      .issue    (dec_issue),
      .to_norm  (dec_norm),
      .cmd_in   (dec_cmd),
      .addr_in  (dec_addr),
      .ba_in    (dec_ba),
      .host_ack (host_ack),
      .cmd_q    (cmd_q),
      .addr_q   (dram_addr),
      .ba_q     (dram_ba),
      .norm_q   (norm_strobe)
   );

   dis_fcs_guard #(
      .FCS_GATE (FCS_GATE)
   ) i_fcs (
      .mode        (mode_q),
      .fast_cs_en  (fast_cs_en),
      .fcs_err     (fcs_err),
      .fast_cs_act (fast_cs_act)
   );

   assign cmd_cs_n  = cmd_q.cs_n;
   assign cmd_ras_n = cmd_q.ras_n;
   assign cmd_cas_n = cmd_q.cas_n;
   assign cmd_we_n  = cmd_q.we_n;

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
   parameter int HA_W     = 32,
   parameter int ADDR_W   = 13,
   parameter int BA_W     = 2,
   parameter int NUM_CKE  = 2,
   parameter int MAP_LSB  = 3,
   parameter int MRS_BITS = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_wr,
   input logic [2:0]         mode_wdata,
   input logic               fast_cs_en,
   input logic               host_req,
   input logic [HA_W-1:0]    host_addr,
   input logic               host_ack,
   input logic               cmd_cs_n,
   input logic               cmd_ras_n,
   input logic               cmd_cas_n,
   input logic               cmd_we_n,
   input logic [ADDR_W-1:0]  dram_addr,
   input logic [BA_W-1:0]    dram_ba,
   input logic [NUM_CKE-1:0] cke,
   input logic               norm_strobe,
   input logic               fcs_err,
   input logic               fast_cs_act
);

   logic lmr_now;
   logic unused_chk;

   assign lmr_now    = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;
   assign unused_chk = ^host_addr;

   // R2: no command reaches the DRAM while its clock is disabled
   assert_no_cmd_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cke[0] |-> cmd_cs_n);

   // R3: a non-zero mode write turns every clock enable on
   assert_cke_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && mode_wdata != 3'b000) |=> (&cke));

   // R3: once on, clock enables stay on
   assert_cke_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|cke) |=> (&cke));

   // R6: register load carries the host address slice, upper bits clear
   assert_lmr_map_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lmr_now |-> ((dram_addr[MRS_BITS-1:0] == $past(host_addr[MAP_LSB +: MRS_BITS]))
                   && ((dram_addr >> MRS_BITS) == '0) && (dram_ba < BA_W'(2))));

   // R10: the normal strobe never coincides with a DRAM command
   assert_norm_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      norm_strobe |-> (cmd_cs_n && $past(host_req)));

   // R11: a command lasts one cycle and is followed by the acknowledge
   assert_ack_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_cs_n |=> (host_ack && cmd_cs_n));

   // R11: a command only follows a sampled request
   assert_cmd_from_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_cs_n |-> $past(host_req));

   // R11: acknowledge is a single-cycle pulse
   assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack |=> !host_ack);

   // R12: an error never coexists with an effective enable
   assert_fcs_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fcs_err |-> (fast_cs_en && !fast_cs_act));

endmodule

bind dram_init_seq dis_checker #(
   .HA_W     (HA_W),
   .ADDR_W   (ADDR_W),
   .BA_W     (BA_W),
   .NUM_CKE  (NUM_CKE),
   .MAP_LSB  (MAP_LSB),
   .MRS_BITS (MRS_BITS)
) i_dis_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_wr     (mode_wr),
   .mode_wdata  (mode_wdata),
   .fast_cs_en  (fast_cs_en),
   .host_req    (host_req),
   .host_addr   (host_addr),
   .host_ack    (host_ack),
   .cmd_cs_n    (cmd_cs_n),
   .cmd_ras_n   (cmd_ras_n),
   .cmd_cas_n   (cmd_cas_n),
   .cmd_we_n    (cmd_we_n),
   .dram_addr   (dram_addr),
   .dram_ba     (dram_ba),
   .cke         (cke),
   .norm_strobe (norm_strobe),
   .fcs_err     (fcs_err),
   .fast_cs_act (fast_cs_act)
);

// File: tb/test_dram_init_seq.sv
`timescale 1ns/1ps
module test_dram_init_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_wdata = 3'b000;
   logic        fast_cs_en = 1'b0;
   logic        host_req = 1'b0;
   logic [31:0] host_addr = 32'h0;
   logic        host_ack;
   logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [12:0] dram_addr;
   logic [1:0]  dram_ba;
   logic [1:0]  cke;
   logic        norm_strobe;
   logic        fcs_err;
   logic        fast_cs_act;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   dram_init_seq i_dram_init_seq (
      .clk (clk), .rst_n (rst_n), .mode_wr (mode_wr), .mode_wdata (mode_wdata),
      .fast_cs_en (fast_cs_en), .host_req (host_req), .host_addr (host_addr),
      .host_ack (host_ack), .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n),
      .cmd_cas_n (cmd_cas_n), .cmd_we_n (cmd_we_n), .dram_addr (dram_addr),
      .dram_ba (dram_ba), .cke (cke), .norm_strobe (norm_strobe),
      .fcs_err (fcs_err), .fast_cs_act (fast_cs_act)
   );

   function automatic logic [3:0] cur_cmd();
      return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
   endfunction

   function automatic bit exp_issue(input logic [2:0] m);
      return (m == 3'b001) || (m == 3'b010) || (m == 3'b011) ||
             (m == 3'b100) || (m == 3'b110);
   endfunction

   function automatic logic [3:0] exp_cmd(input logic [2:0] m);
      case (m)
         3'b001:         return 4'b0111;
         3'b010:         return 4'b0010;
         3'b011, 3'b100: return 4'b0000;
         3'b110:         return 4'b0001;
         default:        return 4'b1111;
      endcase
   endfunction

   function automatic logic [12:0] exp_addr(input logic [2:0] m, input logic [31:0] a);
      if (m == 3'b011 || m == 3'b100) return {2'b00, a[13:3]};
      if (m == 3'b010) return 13'h0400;
      return 13'h0;
   endfunction

   function automatic logic [1:0] exp_ba(input logic [2:0] m);
      return (m == 3'b100) ? 2'b01 : 2'b00;
   endfunction

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'b000: return "R2";
         3'b001: return "R4";
         3'b010: return "R5";
         3'b011: return "R6";
         3'b100: return "R7";
         3'b101: return "R9";
         3'b110: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic write_mode(input logic [2:0] m);
      @(negedge clk);
      mode_wr    = 1'b1;
      mode_wdata = m;
      @(negedge clk);
      mode_wr    = 1'b0;
   endtask

   task automatic run_req(input logic [2:0] m, input logic [31:0] a);
      string t;
      t = tag_of(m);
      @(negedge clk);
      host_req  = 1'b1;
      host_addr = a;
      @(negedge clk);
      host_req  = 1'b0;
      if (exp_issue(m)) begin
         check({t, " cmd"},  32'(cur_cmd()), 32'(exp_cmd(m)));
         check({t, " addr"}, 32'(dram_addr), 32'(exp_addr(m, a)));
         check({t, " ba"},   32'(dram_ba),   32'(exp_ba(m)));
         check("R11 no early ack", 32'(host_ack), 32'd0);
         @(negedge clk);
         check("R11 one-cycle cmd", 32'(cur_cmd()), 32'hF);
         check("R11 ack after cmd", 32'(host_ack), 32'd1);
      end else if (m == 3'b111) begin
         check("R10 strobe", 32'(norm_strobe), 32'd1);
         check("R10 no cmd", 32'(cur_cmd()), 32'hF);
         check("R10 no early ack", 32'(host_ack), 32'd0);
         @(negedge clk);
         check("R10 ack", 32'(host_ack), 32'd1);
         check("R10 strobe one cycle", 32'(norm_strobe), 32'd0);
      end else begin
         check({t, " ack"}, 32'(host_ack), 32'd1);
         check({t, " no cmd"}, 32'(cur_cmd()), 32'hF);
         check({t, " no strobe"}, 32'(norm_strobe), 32'd0);
      end
      @(negedge clk);
      check("R11 ack pulse", 32'(host_ack), 32'd0);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      logic [2:0]  m_cur;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      // R1 reset state, sampled while reset is held
      check("R1 cke", 32'(cke), 32'd0);
      check("R1 cmd", 32'(cur_cmd()), 32'hF);
      check("R1 addr", 32'(dram_addr), 32'd0);
      check("R1 ack", 32'(host_ack), 32'd0);
      check("R1 strobe", 32'(norm_strobe), 32'd0);
      rst_n = 1'b1;
      run_req(3'b000, 32'h0000_1238);
      check("R2 cke after req", 32'(cke), 32'd0);
      write_mode(3'b000);
      check("R2 cke after zero write", 32'(cke), 32'd0);
      // R12 in mode 000
      fast_cs_en = 1'b1;
      #1;
      check("R12 err", 32'(fcs_err), 32'd1);
      check("R12 gated", 32'(fast_cs_act), 32'd0);
      fast_cs_en = 1'b0;
      // R3 first non-zero write
      write_mode(3'b001);
      check("R3 cke on", 32'(cke), 32'd3);
      for (int m = 1; m < 8; m++) begin
         write_mode(3'(m));
         run_req(3'(m), 32'hFFFF_C000 | (32'(m) << 3) | 32'h0000_2AA8);
      end
      // R12 in mode 111
      fast_cs_en = 1'b1;
      #1;
      check("R12 no err", 32'(fcs_err), 32'd0);
      check("R12 pass", 32'(fast_cs_act), 32'd1);
      fast_cs_en = 1'b0;
      write_mode(3'b000);
      check("R3 sticky on zero write", 32'(cke), 32'd3);
      run_req(3'b000, 32'h10);
      // R11 held request in NOP mode
      write_mode(3'b001);
      begin
         int n_cmd = 0;
         int n_ack = 0;
         @(negedge clk);
         host_req = 1'b1;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (!cmd_cs_n) n_cmd++;
            if (host_ack) n_ack++;
         end
         host_req = 1'b0;
         @(negedge clk);
         @(negedge clk);
         check("R11 held cmds", 32'(n_cmd), 32'd2);
         check("R11 held acks", 32'(n_ack), 32'd2);
      end
      // random stimulus
      for (int k = 0; k < 60; k++) begin
         logic [31:0] a;
         m_cur = 3'($urandom_range(1, 7));
         a     = $urandom;
         write_mode(m_cur);
         check("R3 cke random", 32'(cke), 32'd3);
         run_req(m_cur, a);
      end
      // reset mid-run
      write_mode(3'b111);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 cke cleared by reset", 32'(cke), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      run_req(3'b000, 32'h0000_3FF8);
      check("R1 cke low after reset", 32'(cke), 32'd0);
      write_mode(3'b110);
      check("R3 cke after reset write", 32'(cke), 32'd3);
      run_req(3'b110, 32'h0);
      done = 1'b1;
      finish_run();
   end

endmodule